// File: doc/BRIEF.md
# TLB Range Invalidation Engine

A small fully associative translation buffer that takes a single 64-bit command word and removes every cached translation whose page falls inside an address window. The command word holds a base page number and a compact length code. The code is a 4-bit count, a 2-bit scale and a 2-bit granule selector, and the byte length it gives depends on the granule's page size. The command also carries a bitmap of translation regimes, a count of the significant address bits, and a flag telling whether the regime splits its virtual space into two halves. In the split case the base page number is sign-extended.

After it accepts a command, the engine visits one entry per clock. An entry is cleared when it is valid, its regime bit is set in the bitmap, and its page address passes the window test. The significant-bits count can also turn the command into a single-page invalidate or into an invalidate of every entry in the selected regimes. A fill port and a lookup port give access to the stored entries. Both are usable only while the engine is idle.

Top module: `tlb_range_sweep`

## Requirements
- R1: After reset every entry is invalid, so all lookups miss, and `busy` and `done` are low.
- R2: A fill while idle writes the page number, regime and valid bit into the slot it names. A later lookup with the same page number and regime hits and returns that slot (lowest hitting slot wins).
- R3: In window mode the base address is command bits [36:0] shifted left by PAGE_SHIFT. The length is ((count+1) << (5*scale+1)) times the page size, where count is bits [42:39], scale is bits [45:44] and the granule is bits [47:46] (1 = 4 KB, 2 = 16 KB, 3 = 64 KB). Entries whose page address lies in [base, base+length) are cleared.
- R4: When the two-range flag is 1, bit 36 of the base page number is copied into all higher page-number bits. When the flag is 0, those bits are zero.
- R5: An entry whose regime index has a 0 in the command's regime bitmap is never cleared.
- R6: In window mode, granule code 0 gives a zero length, and no entry is cleared.
- R7: A significant-bits count of at least VA_W selects single-page mode. Only entries whose full page address equals the base are cleared, and the length fields, including a zero granule, are ignored.
- R8: A significant-bits count below PAGE_SHIFT selects all-entries mode. Every valid entry of a selected regime is cleared, whatever its address.
- R9: In window mode, only address bits below the significant-bits count take part in the comparison. Higher bits of both the entry and the base are ignored.
- R10: `busy` rises on the edge that accepts a command and stays high for exactly ENTRIES cycles. `done` is high for the single cycle after the last busy cycle.
- R11: While busy, lookups miss, fills are dropped, and new commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe; taken when not busy |
| cmd_word | input | 64 | Encoded base page number and length code |
| cmd_regime_map | input | REGIMES | One bit per regime index to be swept |
| cmd_sig_bits | input | SB_W | Count of significant address bits |
| cmd_two_range | input | 1 | Sign-extend the base page number |
| fill_en | input | 1 | Write an entry (idle only) |
| fill_slot | input | IDX_W | Slot to write |
| fill_vpn | input | VA_W-PAGE_SHIFT | Virtual page number to store |
| fill_regime | input | RG_W | Regime index to store |
| lk_vpn | input | VA_W-PAGE_SHIFT | Lookup virtual page number |
| lk_regime | input | RG_W | Lookup regime index |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_slot | output | IDX_W | Lowest matching slot |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
On every cycle, the assertions check the sweep handshake: a sweep starts only on a command strobe, `done` follows the fall of `busy` for one cycle only, and the latched window stays fixed while the sweep runs. They also check that a valid bit drops only when the sweep clears that slot, and that a fill sets its slot. Which entries a sweep removes cannot be shown by any per-cycle property. That depends on the decoded base and length, sign extension, bit masking, the regime filter and mode selection. Only the bench's scenarios show it: they load a known population, run a command, and read every entry back through the lookup port.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;
   localparam int OP_W      = 64;
   localparam int BPN_LSB   = 0;
   localparam int BPN_W     = 37;
   localparam int CNT_LSB   = 39;
   localparam int SCL_LSB   = 44;
   localparam int GRN_LSB   = 46;

   typedef enum logic [1:0] {
      SW_WINDOW = 2'd0,
      SW_PAGE   = 2'd1,
      SW_ALL    = 2'd2
   } sweep_e;

   // log2 of the page size picked by the granule code; 0 for the invalid code
   function automatic logic [5:0] granule_log2(input logic [1:0] g);
      case (g)
         2'd1:    granule_log2 = 6'd12;
         2'd2:    granule_log2 = 6'd14;
         2'd3:    granule_log2 = 6'd16;
         default: granule_log2 = 6'd0;
      endcase
   endfunction
endpackage

// File: rtl/tlbr_decode.sv
module tlbr_decode
   import tlbr_pkg::*;
#(
   parameter  int VA_W       = 64,
   parameter  int PAGE_SHIFT = 12,
   parameter  int SB_W       = 7,
   localparam int VPN_W      = VA_W - PAGE_SHIFT,
   localparam int EXT_W      = VPN_W - BPN_W,
   localparam int LEN_W      = VA_W + 1
) (
   input  logic [OP_W-1:0] operand,
   input  logic            two_range,
   input  logic [SB_W-1:0] sig_bits,
   output sweep_e          mode,
   output logic [VA_W-1:0] mask,
   output logic [VA_W-1:0] lo,
   output logic [VA_W:0]   hi
);
   initial begin
      if (EXT_W < 1) $fatal(1, "page number field wider than the VPN");
      if ((1 << SB_W) <= VA_W) $fatal(1, "SB_W cannot express VA_W");
   end

   logic [BPN_W-1:0] bpn;
   logic [VPN_W-1:0] vpn;
   logic [VA_W-1:0]  base;
   logic [1:0]       gran, scale;
   logic [3:0]       count;
   logic [5:0]       sh;
   logic [LEN_W-1:0] len;
   logic             unused_fields;

   assign unused_fields = ^{operand[OP_W-1:GRN_LSB+2], operand[SCL_LSB-1],
                            operand[CNT_LSB-1:BPN_W]};

   always_comb begin
      bpn   = operand[BPN_LSB +: BPN_W];
      count = operand[CNT_LSB +: 4];
      scale = operand[SCL_LSB +: 2];
      gran  = operand[GRN_LSB +: 2];
      vpn   = {{EXT_W{two_range & bpn[BPN_W-1]}}, bpn};
      base  = {vpn, {PAGE_SHIFT{1'b0}}};
      sh    = granule_log2(gran) + 6'd1 + 6'(scale) * 6'd5;
      len   = (gran == 2'd0) ? '0 : ((LEN_W'(count) + LEN_W'(1)) << sh);
      if (sig_bits >= SB_W'(VA_W))            mode = SW_PAGE;
      else if (sig_bits < SB_W'(PAGE_SHIFT))  mode = SW_ALL;
      else                                    mode = SW_WINDOW;
      mask  = (mode == SW_WINDOW) ? ~({VA_W{1'b1}} << sig_bits) : {VA_W{1'b1}};
      lo    = base & mask;
      hi    = {1'b0, lo} + len;
   end
endmodule

// File: rtl/tlbr_entry_array.sv
module tlbr_entry_array #(
   parameter  int ENTRIES = 16,
   parameter  int REGIMES = 4,
   parameter  int VPN_W   = 52,
   localparam int IDX_W   = $clog2(ENTRIES),
   localparam int RG_W    = $clog2(REGIMES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_slot,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [RG_W-1:0]    wr_regime,
   input  logic               clr_en,
   input  logic [IDX_W-1:0]   clr_slot,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [RG_W-1:0]    lk_regime,
   output logic [ENTRIES-1:0] lk_match,
   input  logic [IDX_W-1:0]   rd_slot,
   output logic               rd_valid,
   output logic [VPN_W-1:0]   rd_vpn,
   output logic [RG_W-1:0]    rd_regime
);
   logic [ENTRIES-1:0] vld_q;
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [RG_W-1:0]    rgm_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && wr_slot == IDX_W'(i))        vld_q[i] <= 1'b1;
            else if (clr_en && clr_slot == IDX_W'(i)) vld_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         vpn_q[wr_slot] <= wr_vpn;
         rgm_q[wr_slot] <= wr_regime;
      end
   end

   assign rd_valid  = vld_q[rd_slot];
   assign rd_vpn    = vpn_q[rd_slot];
   assign rd_regime = rgm_q[rd_slot];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign lk_match[g] = vld_q[g] && vpn_q[g] == lk_vpn && rgm_q[g] == lk_regime;

      // R5: a valid bit only drops when the sweep clears this very slot
      p_valid_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(vld_q[g]) |-> $past(clr_en) && $past(clr_slot) == IDX_W'(g));
   end

   p_fill_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld_q[$past(wr_slot)]);
endmodule

// File: rtl/tlb_range_sweep.sv
module tlb_range_sweep
   import tlbr_pkg::*;
#(
   parameter  int VA_W       = 64,
   parameter  int PAGE_SHIFT = 12,
   parameter  int ENTRIES    = 16,
   parameter  int REGIMES    = 4,
   parameter  int SB_W       = 7,
   localparam int VPN_W      = VA_W - PAGE_SHIFT,
   localparam int IDX_W      = $clog2(ENTRIES),
   localparam int RG_W       = $clog2(REGIMES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [OP_W-1:0]    cmd_word,
   input  logic [REGIMES-1:0] cmd_regime_map,
   input  logic [SB_W-1:0]    cmd_sig_bits,
   input  logic               cmd_two_range,
   input  logic               fill_en,
   input  logic [IDX_W-1:0]   fill_slot,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic [RG_W-1:0]    fill_regime,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [RG_W-1:0]    lk_regime,
   output logic               lk_hit,
   output logic [IDX_W-1:0]   lk_slot,
   output logic               busy,
   output logic               done
);
   initial begin
      if (ENTRIES < 2) $fatal(1, "ENTRIES must be at least 2");
      if (REGIMES < 2 || (1 << RG_W) != REGIMES) $fatal(1, "REGIMES must be a power of two");
   end

   sweep_e             d_mode, mode_q;
   logic [VA_W-1:0]    d_mask, d_lo, mask_q, lo_q;
   logic [VA_W:0]      d_hi, hi_q;
   logic [REGIMES-1:0] map_q;
   logic               busy_q, done_q, accept, last;
   logic [IDX_W-1:0]   idx_q;
   logic               rd_valid, clr_en, addr_hit;
   logic [VPN_W-1:0]   rd_vpn;
   logic [RG_W-1:0]    rd_regime;
   logic [VA_W-1:0]    ent_addr, ent_m;
   logic [ENTRIES-1:0] lk_match;

   tlbr_decode #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .SB_W(SB_W)) u_dec (
      .operand(cmd_word), .two_range(cmd_two_range), .sig_bits(cmd_sig_bits),
      .mode(d_mode), .mask(d_mask), .lo(d_lo), .hi(d_hi));

   assign accept = cmd_valid & ~busy_q;
   assign last   = idx_q == IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
         mode_q <= SW_WINDOW;
         mask_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         map_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            mode_q <= d_mode;
            mask_q <= d_mask;
            lo_q   <= d_lo;
            hi_q   <= d_hi;
            map_q  <= cmd_regime_map;
         end else if (busy_q) begin
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
            end
         end
      end
   end

   // per-entry window test for the slot under the sweep pointer
   always_comb begin
      ent_addr = {rd_vpn, {PAGE_SHIFT{1'b0}}};
      ent_m    = ent_addr & mask_q;
      case (mode_q)
         SW_PAGE: addr_hit = ent_addr == lo_q;
         SW_ALL:  addr_hit = 1'b1;
         default: addr_hit = (ent_m >= lo_q) && ({1'b0, ent_m} < hi_q);
      endcase
      clr_en = busy_q & rd_valid & map_q[rd_regime] & addr_hit;
   end

   tlbr_entry_array #(.ENTRIES(ENTRIES), .REGIMES(REGIMES), .VPN_W(VPN_W)) u_arr (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fill_en & ~busy_q), .wr_slot(fill_slot), .wr_vpn(fill_vpn), .wr_regime(fill_regime),
      .clr_en(clr_en), .clr_slot(idx_q),
      .lk_vpn(lk_vpn), .lk_regime(lk_regime), .lk_match(lk_match),
      .rd_slot(idx_q), .rd_valid(rd_valid), .rd_vpn(rd_vpn), .rd_regime(rd_regime));

   always_comb begin
      lk_slot = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (lk_match[i]) lk_slot = IDX_W'(i);
   end

   assign lk_hit = (|lk_match) & ~busy_q;
   assign busy   = busy_q;
   assign done   = done_q;

   p_start_on_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(cmd_valid));
   p_done_after_scan_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   p_window_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && $past(busy_q) |-> $stable(lo_q) && $stable(hi_q) && $stable(map_q));
   p_window_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && mode_q == SW_WINDOW |-> {1'b0, lo_q} <= hi_q);
endmodule

// File: tb/tlb_range_sweep_test.sv
`timescale 1ns/1ps
module tlb_range_sweep_test;
   localparam int N = 16;

   typedef struct packed {
      logic [1:0]  gran;
      logic [1:0]  scale;
      logic [3:0]  cnt;
      logic [36:0] bpn;
      logic [3:0]  map;
      logic [6:0]  sb;
      logic        tr;
      logic [15:0] keep;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 2'd0, 4'd1,  37'h100, 4'hF, 7'd56, 1'b0, 16'hFFF0},
      '{2'd1, 2'd0, 4'd1,  37'h100, 4'h5, 7'd56, 1'b0, 16'hFFFA},
      '{2'd2, 2'd0, 4'd0,  37'h100, 4'hF, 7'd56, 1'b0, 16'hFF00},
      '{2'd3, 2'd0, 4'd0,  37'h100, 4'hF, 7'd56, 1'b0, 16'hC000},
      '{2'd3, 2'd0, 4'd0,  37'h100, 4'hF, 7'd63, 1'b0, 16'hE000},
      '{2'd0, 2'd0, 4'd15, 37'h100, 4'hF, 7'd56, 1'b0, 16'hFFFF},
      '{2'd1, 2'd1, 4'd0,  37'h108, 4'hF, 7'd56, 1'b0, 16'hC0FF},
      '{2'd1, 2'd0, 4'd0,  37'h1F_FFFF_FFFF, 4'hF, 7'd63, 1'b1, 16'hBFFF},
      '{2'd1, 2'd0, 4'd0,  37'h1F_FFFF_FFFF, 4'hF, 7'd63, 1'b0, 16'h7FFF},
      '{2'd0, 2'd0, 4'd0,  37'h101, 4'hF, 7'd64, 1'b0, 16'hFFFD},
      '{2'd1, 2'd0, 4'd0,  37'h0,   4'h2, 7'd8,  1'b0, 16'hDDDD},
      '{2'd1, 2'd0, 4'd0,  37'h0,   4'h0, 7'd0,  1'b0, 16'hFFFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [63:0] cmd_word = '0;
   logic [3:0]  cmd_regime_map = '0;
   logic [6:0]  cmd_sig_bits = '0;
   logic        cmd_two_range = 1'b0;
   logic        fill_en = 1'b0;
   logic [3:0]  fill_slot = '0;
   logic [51:0] fill_vpn = '0;
   logic [1:0]  fill_regime = '0;
   logic [51:0] lk_vpn = '0;
   logic [1:0]  lk_regime = '0;
   logic        lk_hit, busy, done;
   logic [3:0]  lk_slot;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   tlb_range_sweep uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .cmd_regime_map(cmd_regime_map), .cmd_sig_bits(cmd_sig_bits),
      .cmd_two_range(cmd_two_range), .fill_en(fill_en), .fill_slot(fill_slot),
      .fill_vpn(fill_vpn), .fill_regime(fill_regime), .lk_vpn(lk_vpn),
      .lk_regime(lk_regime), .lk_hit(lk_hit), .lk_slot(lk_slot),
      .busy(busy), .done(done));

   function automatic logic [51:0] ent_vpn(input int i);
      case (i)
         13:      ent_vpn = 52'hFF0000000010D;
         14:      ent_vpn = 52'hFFFFFFFFFFFFF;
         15:      ent_vpn = 52'h0001FFFFFFFFF;
         default: ent_vpn = 52'h100 + 52'(i);
      endcase
   endfunction

   function automatic logic [1:0] ent_reg(input int i);
      ent_reg = (i >= 14) ? 2'd2 : 2'(i % 4);
   endfunction

   function automatic logic [63:0] mk_word(input logic [1:0] g, input logic [1:0] s,
                                           input logic [3:0] c, input logic [36:0] b);
      mk_word = {16'h0, g, s, 1'b0, c, 2'b00, b};
   endfunction

   function automatic string vtag(input int k);
      case (k)
         1:       vtag = "R5";
         3, 4:    vtag = "R9";
         5:       vtag = "R6";
         7, 8:    vtag = "R4";
         9:       vtag = "R7";
         10, 11:  vtag = "R8";
         default: vtag = "R3";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic fill_all();
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         fill_en = 1'b1; fill_slot = 4'(i); fill_vpn = ent_vpn(i); fill_regime = ent_reg(i);
      end
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic observe(output logic [15:0] m);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         lk_vpn = ent_vpn(i); lk_regime = ent_reg(i);
         #1;
         m[i] = lk_hit && lk_slot == 4'(i);
      end
   endtask

   task automatic issue(input vec_t v, output int nbusy, output bit d0, output bit d1);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_word = mk_word(v.gran, v.scale, v.cnt, v.bpn);
      cmd_regime_map = v.map; cmd_sig_bits = v.sb; cmd_two_range = v.tr;
      @(negedge clk);
      cmd_valid = 1'b0;
      nbusy = 0;
      while (busy && nbusy < 100) begin
         nbusy++;
         @(negedge clk);
      end
      d0 = done;
      @(negedge clk);
      d1 = done;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] m;
      int nb;
      bit d0, d1;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
      observe(m);
      chk(m == 16'h0, "R1", "no valid entries", m, 0);

      // R2: fill then lookup
      @(negedge clk);
      fill_en = 1'b1; fill_slot = 4'd7; fill_vpn = 52'h777; fill_regime = 2'd3;
      @(negedge clk);
      fill_en = 1'b0; lk_vpn = 52'h777; lk_regime = 2'd3;
      #1;
      chk(lk_hit && lk_slot == 4'd7, "R2", "hit on filled slot", {lk_hit, lk_slot}, {1'b1, 4'd7});
      lk_regime = 2'd2;
      #1;
      chk(!lk_hit, "R2", "miss on other regime", lk_hit, 0);

      // table of sweep scenarios
      for (int k = 0; k < NV; k++) begin
         fill_all();
         issue(VECS[k], nb, d0, d1);
         if (k == 0) begin
            chk(nb == N, "R10", "busy cycle count", nb, N);
            chk(d0 == 1'b1, "R10", "done after scan", d0, 1);
            chk(d1 == 1'b0, "R10", "done single pulse", d1, 0);
         end
         observe(m);
         chk(m == VECS[k].keep, vtag(k), $sformatf("surviving entries, vector %0d", k), m, VECS[k].keep);
      end

      // R11: activity during a sweep is ignored
      fill_all();
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_word = mk_word(2'd1, 2'd0, 4'd1, 37'h100);
      cmd_regime_map = 4'hF; cmd_sig_bits = 7'd56; cmd_two_range = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b0;
      @(negedge clk);
      lk_vpn = ent_vpn(5); lk_regime = ent_reg(5);
      fill_en = 1'b1; fill_slot = 4'd5; fill_vpn = 52'h555; fill_regime = 2'd3;
      cmd_valid = 1'b1; cmd_word = '0; cmd_regime_map = 4'hF; cmd_sig_bits = 7'd0;
      #1;
      chk(busy && !lk_hit, "R11", "lookup miss while busy", {busy, lk_hit}, 2'b10);
      @(negedge clk);
      fill_en = 1'b0; cmd_valid = 1'b0;
      nb = 0;
      while (busy && nb < 100) begin
         nb++;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
      chk(!busy, "R11", "no second sweep", busy, 0);
      observe(m);
      chk(m == 16'hFFF0, "R11", "only first command applied", m, 16'hFFF0);
      @(negedge clk);
      lk_vpn = 52'h555; lk_regime = 2'd3;
      #1;
      chk(!lk_hit, "R11", "dropped fill not present", lk_hit, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule